// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit effective address of a memory operand that uses scaled-index addressing. The addressing bytes of an instruction arrive one per cycle on a valid/ready byte stream. The first byte is the operand-mode byte. It is followed by the scale/index/base byte and then by zero, one or four displacement bytes.

The block reads the base and index values from an 8-entry array of 32-bit registers, which is supplied as a flat input vector. Entry k sits in bits `32*k+31 : 32*k`. From these it reports the address together with the number of addressing bytes it consumed.

The byte stream obeys the usual rules:
- A byte is taken only on a clock edge where `in_valid` and `in_ready` are both high.
- The producer may hold `in_valid` low for any number of cycles, and the block keeps its place in the sequence while it waits.
- `in_ready` drops for exactly one cycle while a result is presented. The result is a one-cycle strobe with no back-pressure.

Mode bytes that select any other operand form are rejected with a one-cycle unsupported strobe. In that case only the mode byte is consumed.

Top module: `sib_addr_gen`

## Requirements
- R1: The mode byte is split as mode[7:6], unused[5:3], select[2:0]. Scaled-index addressing is taken when select equals 100 and mode is not 11. Any other mode byte gives `out_unsup` high for one cycle with `out_count` = 1, and the block is ready for a new mode byte on the following cycle.
- R2: The scale/index/base byte is split as scale[7:6], index[5:3], base[2:0]. Scale codes 00, 01, 10 and 11 multiply the index by 1, 2, 4 and 8. The address is base + index*scale + displacement, wrapping modulo 2^32, and register code k reads array entry k.
- R3: Mode 00 with a base code other than 101 has no displacement, and `out_count` = 2.
- R4: Mode 01 takes one displacement byte, sign-extended to 32 bits, and `out_count` = 3.
- R5: Mode 10 takes four displacement bytes, least significant byte first, and `out_count` = 6.
- R6: Mode 00 with base code 101 uses no base register. Four displacement bytes follow, least significant first, and `out_count` = 6.
- R7: Index code 100 contributes zero to the address. Base code 100 reads entry 4 like any other register.
- R8: `in_ready` is high while the block waits for any addressing byte. Cycles with `in_valid` low consume nothing and leave the result unchanged.
- R9: `out_done` and `out_unsup` are single-cycle strobes that are never high together. Each is high in the cycle after the edge that accepts the last byte. `in_ready` is low during either strobe, and `out_addr` is zero whenever `out_done` is low.
- R10: During and after reset, `in_ready` is high and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Addressing byte present |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Addressing byte |
| reg_file | input | 256 | Eight 32-bit register values, entry k at bits 32k+31:32k |
| out_done | output | 1 | Address result strobe |
| out_unsup | output | 1 | Unsupported operand form strobe |
| out_addr | output | 32 | Effective address, valid with out_done |
| out_count | output | 3 | Addressing bytes consumed, valid with either strobe |

## Verification
Both strobes are due exactly one cycle after the rising edge that accepts the last needed byte. That byte is the mode byte for a rejected form, the scale/index/base byte when there is no displacement, and the final displacement byte otherwise. The bench therefore samples the result at the falling edge right after that acceptance edge. It samples again one falling edge later to confirm that the strobe is gone and `in_ready` has returned. The expected address and count are computed arithmetically from the three mode values and every scale/index/base byte, and the same cases are repeated with idle gaps inserted between bytes.

// File: rtl/sib_pkg.sv
package sib_pkg;

  localparam int BYTE_W = 8;
  localparam int DISP_W = 32;
  localparam int LEN_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SIB,
    ST_DISP,
    ST_DONE,
    ST_UNSUP
  } sib_state_t;

  typedef struct packed {
    logic [1:0] scale;
    logic [2:0] index;
    logic [2:0] base;
  } sib_fields_t;

  localparam logic [2:0] SEL_SCALED = 3'b100;
  localparam logic [2:0] IDX_NONE   = 3'b100;
  localparam logic [2:0] BASE_DISP  = 3'b101;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_D8     = 2'b01;
  localparam logic [1:0] MODE_D32    = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;

  // Number of displacement bytes implied by the mode and the base code.
  function automatic logic [LEN_W-1:0] disp_len(input logic [1:0] mode,
                                                 input logic [2:0] base);
    logic [LEN_W-1:0] n;
    case (mode)
      MODE_D8:     n = 3'd1;
      MODE_D32:    n = 3'd4;
      MODE_NODISP: n = (base == BASE_DISP) ? 3'd4 : 3'd0;
      default:     n = 3'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sib_ctrl.sv
module sib_ctrl
  import sib_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                in_ready,
  output logic                done,
  output logic                unsup,
  output logic [LEN_W-1:0]    count,
  output logic [1:0]          mode_q,
  output sib_fields_t         sib_q,
  output logic [LEN_W-1:0]    len_q,
  output logic                disp_clr,
  output logic                disp_we,
  output logic [1:0]          disp_idx
);

  sib_state_t      st, st_n;
  logic            fire;
  logic            scaled_form;
  logic [LEN_W-1:0] len_new;
  logic [1:0]      idx_q;

  assign in_ready    = (st == ST_IDLE) || (st == ST_SIB) || (st == ST_DISP);
  assign fire        = in_valid && in_ready;
  assign scaled_form = (in_data[2:0] == SEL_SCALED) && (in_data[7:6] != MODE_REG);
  assign len_new     = disp_len(mode_q, in_data[2:0]);

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: if (fire) st_n = scaled_form ? ST_SIB : ST_UNSUP;
      ST_SIB:  if (fire) st_n = (len_new == '0) ? ST_DONE : ST_DISP;
      ST_DISP: if (fire && ({1'b0, idx_q} == len_q - 3'd1)) st_n = ST_DONE;
      ST_DONE:  st_n = ST_IDLE;
      ST_UNSUP: st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= '0;
      sib_q  <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else begin
      st <= st_n;
      if (st == ST_IDLE && fire) mode_q <= in_data[7:6];
      if (st == ST_SIB && fire) begin
        sib_q <= sib_fields_t'(in_data);
        len_q <= len_new;
        idx_q <= '0;
      end
      if (st == ST_DISP && fire) idx_q <= idx_q + 2'd1;
    end
  end

  assign done     = (st == ST_DONE);
  assign unsup    = (st == ST_UNSUP);
  assign count    = unsup ? 3'd1 : (done ? 3'd2 + len_q : 3'd0);
  assign disp_clr = (st == ST_SIB) && fire;
  assign disp_we  = (st == ST_DISP) && fire;
  assign disp_idx = idx_q;

endmodule

// File: rtl/sib_disp_asm.sv
module sib_disp_asm
  import sib_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               we,
  input  logic [1:0]         idx,
  input  logic [BYTE_W-1:0]  din,
  input  logic [LEN_W-1:0]   len,
  output logic [DISP_W-1:0]  disp_ext
);

  logic [DISP_W-1:0] raw;

  // Bytes land least significant first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   raw <= '0;
    else if (clr) raw <= '0;
    else if (we)  raw[{idx, 3'b000} +: BYTE_W] <= din;
  end

  always_comb begin
    case (len)
      3'd1:    disp_ext = {{(DISP_W-BYTE_W){raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
      3'd4:    disp_ext = raw;
      default: disp_ext = '0;
    endcase
  end

endmodule

// File: rtl/sib_agu.sv
module sib_agu
  import sib_pkg::*;
#(
  parameter int NREG = 8,
  parameter int RW   = 32
) (
  input  logic [NREG*RW-1:0] reg_file,
  input  logic [1:0]         mode,
  input  sib_fields_t        sib,
  input  logic [RW-1:0]      disp,
  output logic [RW-1:0]      addr
);

  logic [RW-1:0] regs [NREG];
  logic [RW-1:0] base_v, idx_raw, idx_v;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign regs[g] = reg_file[g*RW +: RW];
  end

  assign base_v  = (mode == MODE_NODISP && sib.base == BASE_DISP) ? '0 : regs[sib.base];
  assign idx_raw = (sib.index == IDX_NONE) ? '0 : regs[sib.index];

  always_comb begin
    case (sib.scale)
      2'd0:    idx_v = idx_raw;
      2'd1:    idx_v = {idx_raw[RW-2:0], 1'b0};
      2'd2:    idx_v = {idx_raw[RW-3:0], 2'b00};
      default: idx_v = {idx_raw[RW-4:0], 3'b000};
    endcase
  end

  assign addr = base_v + idx_v + disp;

endmodule

// File: rtl/sib_addr_gen.sv
module sib_addr_gen
  import sib_pkg::*;
#(
  parameter int NREG = 8,
  parameter int RW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic [NREG*RW-1:0] reg_file,
  output logic               out_done,
  output logic               out_unsup,
  output logic [RW-1:0]      out_addr,
  output logic [2:0]         out_count
);

  logic [1:0]       mode_q;
  sib_fields_t      sib_q;
  logic [LEN_W-1:0] len_q;
  logic             disp_clr, disp_we;
  logic [1:0]       disp_idx;
  logic [DISP_W-1:0] disp_ext;
  logic [RW-1:0]    sum;

  sib_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .done(out_done), .unsup(out_unsup), .count(out_count),
    .mode_q(mode_q), .sib_q(sib_q), .len_q(len_q),
    .disp_clr(disp_clr), .disp_we(disp_we), .disp_idx(disp_idx)
  );

  sib_disp_asm u_disp (
    .clk(clk), .rst_n(rst_n), .clr(disp_clr), .we(disp_we), .idx(disp_idx),
    .din(in_data), .len(len_q), .disp_ext(disp_ext)
  );

  sib_agu #(.NREG(NREG), .RW(RW)) u_agu (
    .reg_file(reg_file), .mode(mode_q), .sib(sib_q),
    .disp(RW'(disp_ext)), .addr(sum)
  );

  assign out_addr = out_done ? sum : '0;

endmodule

// File: rtl/sib_addr_gen_chk.sv
module sib_addr_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_done,
  input logic       out_unsup,
  input logic [2:0] out_count
);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_done && out_unsup));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done || out_unsup) |-> !in_ready);

  assert_ready_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done || out_unsup) |=> in_ready);

  assert_unsup_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_unsup |-> (out_count == 3'd1));

  assert_done_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_count == 3'd2 || out_count == 3'd3 || out_count == 3'd6));

endmodule

bind sib_addr_gen sib_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .out_done(out_done), .out_unsup(out_unsup), .out_count(out_count)
);

// File: tb/tb_sib_addr_gen.sv
module tb_sib_addr_gen;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [7:0]   in_data;
  logic [255:0] reg_file;
  logic         out_done, out_unsup;
  logic [31:0]  out_addr;
  logic [2:0]   out_count;
  logic [31:0]  regv [8];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_regs
    assign reg_file[g*32 +: 32] = regv[g];
  end

  sib_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .reg_file(reg_file), .out_done(out_done),
    .out_unsup(out_unsup), .out_addr(out_addr), .out_count(out_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'h5A;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_data  = 8'h5A;
  endtask

  task automatic run_op(input logic [1:0] mode, input logic [7:0] sib, input int gap,
                        input string tag);
    logic [31:0] disp32, dispv, basev, idxv, exp;
    int len;
    disp32 = {sib, ~sib, sib ^ 8'h3C, sib + 8'h81};
    if (mode == 2'b01) len = 1;
    else if (mode == 2'b10) len = 4;
    else len = (sib[2:0] == 3'b101) ? 4 : 0;
    if (len == 1) dispv = {{24{disp32[7]}}, disp32[7:0]};
    else if (len == 4) dispv = disp32;
    else dispv = 32'd0;
    basev = (mode == 2'b00 && sib[2:0] == 3'b101) ? 32'd0 : regv[sib[2:0]];
    idxv  = (sib[5:3] == 3'b100) ? 32'd0 : (regv[sib[5:3]] << sib[7:6]);
    exp   = basev + idxv + dispv;
    send_byte({mode, sib[5:3], 3'b100}, gap);
    send_byte(sib, gap);
    for (int i = 0; i < len; i++) send_byte(disp32[8*i +: 8], gap);
    @(negedge clk);
    chk({tag, " done"}, {31'd0, out_done}, 32'd1);
    chk({tag, " unsup R9"}, {31'd0, out_unsup}, 32'd0);
    chk({tag, " addr R2"}, out_addr, exp);
    chk({tag, " count"}, {29'd0, out_count}, 32'(2 + len));
    @(negedge clk);
    chk({tag, " strobe pulse R9"}, {31'd0, out_done}, 32'd0);
    chk({tag, " addr zero R9"}, out_addr, 32'd0);
    chk({tag, " ready back R8"}, {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) regv[i] = 32'h2468ACE1 * (i + 3);
    regv[7] = 32'hFFFF_FFF0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    repeat (3) @(negedge clk);
    chk("reset ready R10", {31'd0, in_ready}, 32'd1);
    chk("reset done R10", {31'd0, out_done}, 32'd0);
    chk("reset unsup R10", {31'd0, out_unsup}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("post reset ready R10", {31'd0, in_ready}, 32'd1);

    // Full sweep over modes and all scale/index/base bytes.
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 256; s++) begin
        string tag;
        if (m == 0 && s[2:0] == 3'b101) tag = "R6";
        else if (s[5:3] == 3'b100 || s[2:0] == 3'b100) tag = "R7";
        else if (m == 0) tag = "R3";
        else if (m == 1) tag = "R4";
        else tag = "R5";
        run_op(2'(m), 8'(s), 0, tag);
      end
    end

    // Idle gaps between bytes.
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 256; s += 37) run_op(2'(m), 8'(s), 2, "R8 gap");
    end

    // Every rejected mode byte.
    for (int b = 0; b < 256; b++) begin
      if (b[2:0] == 3'b100 && b[7:6] != 2'b11) continue;
      send_byte(8'(b), 0);
      @(negedge clk);
      chk("R1 unsup strobe", {31'd0, out_unsup}, 32'd1);
      chk("R1 no done", {31'd0, out_done}, 32'd0);
      chk("R1 count", {29'd0, out_count}, 32'd1);
      chk("R9 ready low", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
      chk("R1 unsup pulse", {31'd0, out_unsup}, 32'd0);
      chk("R1 ready back", {31'd0, in_ready}, 32'd1);
    end

    // A rejected byte followed at once by a valid sequence.
    run_op(2'b10, 8'hC1, 0, "R1 after unsup R5");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule